// File: doc/BRIEF.md
# Adjustable IO Voltage Mode Controller

This block produces the 3-bit select code for an adjustable IO supply regulator. It also drives the mezzanine power enable and the power-good enable. The code can come from three sources:

- a 3-position DIP bank, available on newer boards only;
- a legacy bank of two switches;
- fields written by software into a GPIO-style register.

The block picks the source while reset is held and keeps that choice until the next reset. Switch changes made during operation therefore alter the voltage only within the chosen source. They never move control to another source.

Outputs are registered. A voltage code, enable or power-good value follows its inputs one clock after the inputs are sampled. Status bits report the chosen source. While the DIP bank is in control, the two legacy switches no longer select a voltage, so they are passed out as general user inputs. Codes such as 0.8 V and the reserved code are driven exactly as received. The block substitutes nothing.

Top module: `vio_mode_ctrl`

## Requirements
- R1: On every clock edge while `rst_n` is low, the source is re-evaluated. Bank source is chosen only when `new_rev`=1 and at least one `bank_sw` bit is 1 (1 = switch on). The value evaluated at the last reset edge is kept.
- R2: Otherwise the legacy switches decide. `{leg_sw[1],leg_sw[0]}`=2'b11 selects register source, and any other pattern selects legacy source.
- R3: After reset is released, the source never changes until `rst_n` goes low again, whatever the switches do.
- R4: In bank source, `vid` becomes the bitwise inverse of `bank_sw` one clock later, so all-on gives 3'b000 (3.3 V).
- R5: In legacy source, `{leg_sw[1],leg_sw[0]}` maps as follows, one clock later: 2'b00 gives `vid`=3'b010 (1.8 V), 2'b01 gives 3'b001 (2.5 V) and 2'b10 gives 3'b000 (3.3 V). With 2'b11, `vid` keeps its previous value.
- R6: In register source, `vid` equals `reg_vid` (register bits 6:4) one clock later. This includes 3'b110 (0.8 V) and the reserved 3'b111, both unchanged.
- R7: In register source, `pwr_en` follows `reg_pwr` (register bit 7) and `pg_en` follows `reg_pg` (register bit 3), one clock later. In any other source, both are 1 one clock after reset release.
- R8: `stat_reg_mode` is 1 only in register source. `stat_vid_src` is 0 only in bank source.
- R9: In bank source, `user_sw` equals `leg_sw`, and neither `leg_sw` nor the register fields affect `vid`, `pwr_en` or `pg_en`. In any other source, `user_sw` is 2'b00.
- R10: While `rst_n` is low, `vid`=3'b010 and `pwr_en`=`pg_en`=0 one clock after the first reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| new_rev | input | 1 | 1 on board revisions that carry the DIP bank |
| bank_sw | input | 3 | DIP bank levels, 1 = on |
| leg_sw | input | 2 | Legacy switch levels, 1 = on |
| reg_pwr | input | 1 | Register bit 7: mezzanine power enable |
| reg_vid | input | 3 | Register bits 6:4: voltage code |
| reg_pg | input | 1 | Register bit 3: power-good enable |
| vid | output | 3 | Regulator voltage select code |
| pwr_en | output | 1 | Mezzanine power enable |
| pg_en | output | 1 | Power-good enable toward the mezzanine |
| stat_reg_mode | output | 1 | 1 when register source is active |
| stat_vid_src | output | 1 | 0 for bank source, 1 for legacy or register |
| user_sw | output | 2 | Legacy switches freed as user input in bank source |

## Verification
The assertions check the following on every cycle:

- the source is stable after reset release;
- the bank inversion, the register pass-through and the enable levels hold in each source;
- `user_sw` is zero outside bank source;
- the source latched at release matches the inputs of the last reset edge.

The bench scenarios are needed for the rest. They show the legacy decode table and its hold on the on/on pattern. They also show that late switch changes and register writes have no effect in bank source, and that the reserved and 0.8 V codes arrive unaltered.

// File: rtl/vio_mode_pkg.sv
package vio_mode_pkg;
  localparam int VID_W = 3;
  localparam int LEG_W = 2;

  typedef enum logic [1:0] {
    SRC_BANK   = 2'd0,
    SRC_LEGACY = 2'd1,
    SRC_REG    = 2'd2
  } vsrc_t;

  // Legacy pair selects register control when both switches are on.
  function automatic logic legacy_is_reg(input logic [LEG_W-1:0] leg);
    return &leg;
  endfunction

  function automatic vsrc_t pick_src(input logic new_rev,
                                     input logic [VID_W-1:0] bank,
                                     input logic [LEG_W-1:0] leg);
    if (new_rev && (|bank)) return SRC_BANK;
    if (legacy_is_reg(leg)) return SRC_REG;
    return SRC_LEGACY;
  endfunction

  // An on switch maps to a zero code bit.
  function automatic logic [VID_W-1:0] bank_code(input logic [VID_W-1:0] bank);
    return ~bank;
  endfunction

  function automatic logic [VID_W-1:0] legacy_code(input logic [LEG_W-1:0] leg);
    case (leg)
      2'b00:   return 3'b010;
      2'b01:   return 3'b001;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/vio_src_latch.sv
module vio_src_latch
  import vio_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             new_rev,
  input  logic [VID_W-1:0] bank_sw,
  input  logic [LEG_W-1:0] leg_sw,
  output vsrc_t            src_q
);
  vsrc_t src_pick;

  assign src_pick = pick_src(new_rev, bank_sw, leg_sw);

  // Loaded on every reset edge; frozen once reset is released.
  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= src_pick;
  end
endmodule

// File: rtl/vio_drive.sv
module vio_drive
  import vio_mode_pkg::*;
#(
  parameter logic [VID_W-1:0] RST_VID = 3'b010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  vsrc_t            src,
  input  logic [VID_W-1:0] bank_sw,
  input  logic [LEG_W-1:0] leg_sw,
  input  logic             reg_pwr,
  input  logic [VID_W-1:0] reg_vid,
  input  logic             reg_pg,
  output logic [VID_W-1:0] vid_q,
  output logic             pwr_q,
  output logic             pg_q
);
  logic [VID_W-1:0] vid_n;
  logic             pwr_n;
  logic             pg_n;

  always_comb begin
    vid_n = vid_q;
    pwr_n = 1'b1;
    pg_n  = 1'b1;
    case (src)
      SRC_BANK:   vid_n = bank_code(bank_sw);
      SRC_LEGACY: if (!legacy_is_reg(leg_sw)) vid_n = legacy_code(leg_sw);
      SRC_REG: begin
        vid_n = reg_vid;
        pwr_n = reg_pwr;
        pg_n  = reg_pg;
      end
      default: vid_n = vid_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid_q <= RST_VID;
      pwr_q <= 1'b0;
      pg_q  <= 1'b0;
    end else begin
      vid_q <= vid_n;
      pwr_q <= pwr_n;
      pg_q  <= pg_n;
    end
  end
endmodule

// File: rtl/vio_mode_ctrl.sv
module vio_mode_ctrl
  import vio_mode_pkg::*;
#(
  parameter logic [VID_W-1:0] RST_VID = 3'b010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             new_rev,
  input  logic [VID_W-1:0] bank_sw,
  input  logic [LEG_W-1:0] leg_sw,
  input  logic             reg_pwr,
  input  logic [VID_W-1:0] reg_vid,
  input  logic             reg_pg,
  output logic [VID_W-1:0] vid,
  output logic             pwr_en,
  output logic             pg_en,
  output logic             stat_reg_mode,
  output logic             stat_vid_src,
  output logic [LEG_W-1:0] user_sw
);
  vsrc_t src;
  logic  src_is_bank;
  logic  src_is_reg;

  vio_src_latch u_latch (
    .clk(clk), .rst_n(rst_n), .new_rev(new_rev),
    .bank_sw(bank_sw), .leg_sw(leg_sw), .src_q(src)
  );

  vio_drive #(.RST_VID(RST_VID)) u_drive (
    .clk(clk), .rst_n(rst_n), .src(src),
    .bank_sw(bank_sw), .leg_sw(leg_sw),
    .reg_pwr(reg_pwr), .reg_vid(reg_vid), .reg_pg(reg_pg),
    .vid_q(vid), .pwr_q(pwr_en), .pg_q(pg_en)
  );

  assign src_is_bank   = (src == SRC_BANK);
  assign src_is_reg    = (src == SRC_REG);
  assign stat_reg_mode = src_is_reg;
  assign stat_vid_src  = !src_is_bank;

  for (genvar i = 0; i < LEG_W; i++) begin : g_user
    assign user_sw[i] = src_is_bank & leg_sw[i];
  end
endmodule

// File: rtl/vio_mode_ctrl_chk.sv
module vio_mode_ctrl_chk
  import vio_mode_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             new_rev,
  input logic [VID_W-1:0] bank_sw,
  input logic [VID_W-1:0] reg_vid,
  input logic             reg_pwr,
  input logic             reg_pg,
  input logic [VID_W-1:0] vid,
  input logic             pwr_en,
  input logic             pg_en,
  input logic             stat_reg_mode,
  input logic             stat_vid_src,
  input logic [LEG_W-1:0] user_sw
);
  // R1
  src_choice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (stat_vid_src == !($past(new_rev) && (|$past(bank_sw)))));

  // R3
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(stat_reg_mode) && $stable(stat_vid_src)));

  // R4
  bank_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_vid_src |=> (vid == ~$past(bank_sw)));

  // R6
  reg_vid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_reg_mode |=> (vid == $past(reg_vid)));

  // R7
  reg_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_reg_mode |=> (pwr_en == $past(reg_pwr) && pg_en == $past(reg_pg)));

  // R7
  fixed_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_reg_mode |=> (pwr_en && pg_en));

  // R8
  stat_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_reg_mode |-> stat_vid_src);

  // R9
  user_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vid_src |-> (user_sw == '0));

  // R10
  rst_out_chk: assert property (@(posedge clk)
    !rst_n |=> (!pwr_en && !pg_en));
endmodule

bind vio_mode_ctrl vio_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .new_rev(new_rev), .bank_sw(bank_sw),
  .reg_vid(reg_vid), .reg_pwr(reg_pwr), .reg_pg(reg_pg),
  .vid(vid), .pwr_en(pwr_en), .pg_en(pg_en),
  .stat_reg_mode(stat_reg_mode), .stat_vid_src(stat_vid_src),
  .user_sw(user_sw)
);

// File: tb/test_vio_mode_ctrl.sv
module test_vio_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       new_rev = 1'b0;
  logic [2:0] bank_sw = 3'b000;
  logic [1:0] leg_sw = 2'b00;
  logic       reg_pwr = 1'b0;
  logic [2:0] reg_vid = 3'b000;
  logic       reg_pg = 1'b0;
  logic [2:0] vid;
  logic       pwr_en, pg_en, stat_reg_mode, stat_vid_src;
  logic [1:0] user_sw;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vio_mode_ctrl i_vio_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .new_rev(new_rev), .bank_sw(bank_sw),
    .leg_sw(leg_sw), .reg_pwr(reg_pwr), .reg_vid(reg_vid), .reg_pg(reg_pg),
    .vid(vid), .pwr_en(pwr_en), .pg_en(pg_en),
    .stat_reg_mode(stat_reg_mode), .stat_vid_src(stat_vid_src),
    .user_sw(user_sw)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Inputs applied, reset held three edges, released; outputs valid after one more edge.
  task automatic boot(input logic rev, input logic [2:0] bank, input logic [1:0] leg);
    @(negedge clk);
    rst_n = 1'b0; new_rev = rev; bank_sw = bank; leg_sw = leg;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_pwr = 1'b1; reg_pg = 1'b1;
    step(); step();
    chk("R10 vid in reset", {5'd0, vid}, 8'h02);
    chk("R10 enables in reset", {6'd0, pwr_en, pg_en}, 8'h00);
  endtask

  task automatic t_bank();
    boot(1'b1, 3'b111, 2'b10);
    chk("R1 bank chosen", {6'd0, stat_reg_mode, stat_vid_src}, 8'h00);
    chk("R4 all on", {5'd0, vid}, 8'h00);
    chk("R7 enables high in bank", {6'd0, pwr_en, pg_en}, 8'h03);
    chk("R9 user_sw passes", {6'd0, user_sw}, 8'h02);
    bank_sw = 3'b010; step();
    chk("R4 inverse", {5'd0, vid}, 8'h05);
    bank_sw = 3'b000; step();
    chk("R3 bank held all off", {5'd0, vid, stat_vid_src}, 8'h0E);
    leg_sw = 2'b11; reg_pwr = 1'b0; reg_pg = 1'b0; reg_vid = 3'b011; step();
    chk("R9 no effect vid", {5'd0, vid}, 8'h07);
    chk("R9 no effect en", {6'd0, pwr_en, pg_en}, 8'h03);
    chk("R9 user follows", {6'd0, user_sw}, 8'h03);
  endtask

  task automatic t_legacy();
    boot(1'b0, 3'b111, 2'b00);
    chk("R2 legacy chosen", {6'd0, stat_reg_mode, stat_vid_src}, 8'h01);
    chk("R5 off/off", {5'd0, vid}, 8'h02);
    chk("R9 user zero", {6'd0, user_sw}, 8'h00);
    leg_sw = 2'b01; step();
    chk("R5 off/on", {5'd0, vid}, 8'h01);
    leg_sw = 2'b10; step();
    chk("R5 on/off", {5'd0, vid}, 8'h00);
    leg_sw = 2'b11; reg_vid = 3'b110; step(); step();
    chk("R5 on/on holds", {5'd0, vid}, 8'h00);
    chk("R3 legacy held", {6'd0, stat_reg_mode, stat_vid_src}, 8'h01);
  endtask

  task automatic t_register();
    reg_pwr = 1'b0; reg_vid = 3'b110; reg_pg = 1'b1;
    boot(1'b1, 3'b000, 2'b11);
    chk("R2 register chosen", {6'd0, stat_reg_mode, stat_vid_src}, 8'h03);
    chk("R6 0.8V code", {5'd0, vid}, 8'h06);
    chk("R7 follow reg", {6'd0, pwr_en, pg_en}, 8'h01);
    reg_pwr = 1'b1; reg_vid = 3'b111; reg_pg = 1'b0; step();
    chk("R6 reserved code", {5'd0, vid}, 8'h07);
    chk("R7 follow reg 2", {6'd0, pwr_en, pg_en}, 8'h02);
    bank_sw = 3'b111; leg_sw = 2'b00; reg_vid = 3'b100; step();
    chk("R3 register held", {5'd0, stat_reg_mode, stat_vid_src, 1'b0}, 8'h06);
    chk("R6 after switch change", {5'd0, vid}, 8'h04);
  endtask

  task automatic t_newrev_fallback();
    boot(1'b1, 3'b000, 2'b01);
    chk("R2 newrev all off legacy", {6'd0, stat_reg_mode, stat_vid_src}, 8'h01);
    chk("R5 off/on newrev", {5'd0, vid}, 8'h01);
  endtask

  initial begin
    t_reset();
    t_bank();
    t_legacy();
    t_register();
    t_newrev_fallback();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule